// File: doc/BRIEF.md
# Line-Rate Control Register Slave on a Management Serial Bus

This block is a passive responder on a Clause 22 MDIO management bus. It watches the data line that the MAC drives, oversampling both the management clock and the data with the local system clock. It decodes each frame: the run of preamble ones, the start pattern, the opcode, the 5-bit PHY address, the 5-bit register address, the turnaround and the 16-bit data word. The block acts only on frames whose PHY address equals its own build-time address. That address must be chosen apart from the one the board PHY answers to, so that the two never collide.

The block holds a small register window. A control register at address 0x10 carries the line-rate code and a reset request. A register at 0x11 holds a 5-bit address for the external PHY. A write frame latches its data word into the addressed register. A read frame makes the block take over the return path after the first turnaround bit and shift the register contents back, most significant bit first. The line-rate code and a one-cycle reset pulse leave the block as plain outputs, for the clocking logic of the interface converter around it.

Top module: `mdio_rate_ctrl`

## Requirements
- R1: After reset, `line_rate` is 00, `core_reset` is 0, `mdio_oe` is 0, `mdio_mac_in` is 1, and `ext_phy_addr` is 0x1F.
- R2: `line_rate` is the pair {bit 6, bit 13} of the control register at 0x10. The codes are 00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s and 11 = reserved; a reserved code is passed through unchanged. `line_rate` changes only on an accepted write to 0x10.
- R3: A read of 0x10 returns the last value written there, with bit 15 always reading 0. Reserved bits keep whatever was written to them.
- R4: A write to 0x10 with bit 15 set raises `core_reset` for exactly one clock and clears the whole control register to 0x0000, so `line_rate` becomes 00.
- R5: A frame whose PHY address differs from the parameter `PHY_ADDR` changes no register, and the block never drives the line during that frame.
- R6: Address 0x11 stores data bits 4:0, which appear on `ext_phy_addr`. It reads back with bits 15:5 as 0, and `ext_phy_addr` changes only on an accepted write to 0x11.
- R7: Within the block's own PHY address, a read of any address other than 0x10 and 0x11 returns 0x0000, and a write to such an address changes nothing.
- R8: In a read frame, the line is undriven during the first turnaround bit and driven to 0 during the second. Data follows MSB first, and the line is released after bit 0. Whenever the line is not driven, `mdio_mac_in` idles at 1.
- R9: A start pattern 01 is accepted only after at least 32 consecutive preamble ones. A frame with 31 ones is ignored.
- R10: Opcode 01 is a write and 10 is a read. A frame with opcode 00 or 11 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the management bus |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock from the MAC; data is taken on its rising edge |
| mdio_mac_out | input | 1 | Data line as driven by the MAC |
| mdio_mac_in | output | 1 | Return data line toward the MAC; 1 when not driven |
| mdio_oe | output | 1 | High while the block drives the return line |
| line_rate | output | 2 | Selected line-rate code {ctrl[6], ctrl[13]} |
| core_reset | output | 1 | One-clock reset request from control bit 15 |
| ext_phy_addr | output | 5 | External PHY address held at 0x11 |

## Verification
A decoder that has lost its frame position shows at the ports within one frame. A read then returns a word shifted by one or more bits, or the line is driven during the first turnaround bit. A write lands in the wrong register, so `line_rate` or `ext_phy_addr` moves when it should not. Either error is visible at the next read-back. A stale preamble counter shows up straight away: a frame with a short preamble is accepted, and its data reaches `line_rate` a few clocks after the last data bit. A reset bit that fails to clear itself appears as a `core_reset` pulse longer than one clock, or as bit 15 reading back as 1.

// File: rtl/mdio_rate_pkg.sv
package mdio_rate_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int HDR_W   = 2 + 2 * ADDR_W;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;

    typedef enum logic [2:0] {
        RX_PREAMBLE,
        RX_START,
        RX_HEADER,
        RX_TURN,
        RX_DATA
    } rx_state_e;

    typedef enum logic [1:0] {
        RATE_10M   = 2'b00,
        RATE_100M  = 2'b01,
        RATE_1G    = 2'b10,
        RATE_RSVD  = 2'b11
    } rate_e;

    typedef struct packed {
        logic [1:0]        opc;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
    } frame_hdr_t;

    typedef struct packed {
        logic              stb;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    function automatic rate_e rate_from_ctrl(input logic [DATA_W-1:0] c);
        return rate_e'({c[6], c[13]});
    endfunction

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] rst_val,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= rst_val;
                    else     chain[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= rst_val;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
    import mdio_rate_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR = 5'h02,
    parameter int                PRE_MIN  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdc_s,
    input  logic              mdio_s,
    input  logic [DATA_W-1:0] rdata,
    output frame_hdr_t        hdr,
    output logic              frame_match,
    output reg_wr_t           wr_req,
    output logic              drv_en,
    output logic              drv_val
);
    localparam int PCW = $clog2(PRE_MIN + 1);
    localparam int BCW = $clog2(DATA_W);

    rx_state_e         state;
    logic              mdc_d;
    logic              rise;
    logic [PCW-1:0]    pre_cnt;
    logic [BCW-1:0]    bit_cnt;
    logic              is_read;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    frame_hdr_t        hdr_next;

    assign rise     = mdc_s & ~mdc_d;
    assign hdr_next = frame_hdr_t'({hdr[HDR_W-2:0], mdio_s});

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= RX_PREAMBLE;
            mdc_d       <= 1'b0;
            pre_cnt     <= '0;
            bit_cnt     <= '0;
            hdr         <= '0;
            frame_match <= 1'b0;
            is_read     <= 1'b0;
            tx_sh       <= '0;
            rx_sh       <= '0;
            wr_req      <= '0;
            drv_en      <= 1'b0;
            drv_val     <= 1'b1;
        end else begin
            mdc_d      <= mdc_s;
            wr_req.stb <= 1'b0;
            if (rise) begin
                unique case (state)
                    RX_PREAMBLE: begin
                        if (mdio_s) begin
                            if (pre_cnt < PCW'(PRE_MIN)) pre_cnt <= pre_cnt + 1'b1;
                        end else if (pre_cnt >= PCW'(PRE_MIN)) begin
                            state <= RX_START;
                        end else begin
                            pre_cnt <= '0;
                        end
                    end
                    RX_START: begin
                        pre_cnt <= '0;
                        bit_cnt <= '0;
                        state   <= mdio_s ? RX_HEADER : RX_PREAMBLE;
                    end
                    RX_HEADER: begin
                        hdr     <= hdr_next;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BCW'(HDR_W - 1)) begin
                            bit_cnt     <= '0;
                            frame_match <= (hdr_next.phy == PHY_ADDR);
                            is_read     <= (hdr_next.opc == OPC_READ);
                            if (hdr_next.opc == OPC_READ || hdr_next.opc == OPC_WRITE)
                                state <= RX_TURN;
                            else
                                state <= RX_PREAMBLE;
                        end
                    end
                    RX_TURN: begin
                        if (bit_cnt == '0) begin
                            bit_cnt <= 1'b1;
                            if (is_read && frame_match) begin
                                drv_en  <= 1'b1;
                                drv_val <= 1'b0;
                                tx_sh   <= rdata;
                            end
                        end else begin
                            bit_cnt <= '0;
                            state   <= RX_DATA;
                            if (drv_en) begin
                                drv_val <= tx_sh[DATA_W-1];
                                tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                            end
                        end
                    end
                    RX_DATA: begin
                        rx_sh   <= {rx_sh[DATA_W-2:0], mdio_s};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BCW'(DATA_W - 1)) begin
                            drv_en  <= 1'b0;
                            drv_val <= 1'b1;
                            state   <= RX_PREAMBLE;
                            if (!is_read && frame_match) begin
                                wr_req.stb  <= 1'b1;
                                wr_req.addr <= hdr.regad;
                                wr_req.data <= {rx_sh[DATA_W-2:0], mdio_s};
                            end
                        end else if (drv_en) begin
                            drv_val <= tx_sh[DATA_W-1];
                            tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                        end
                    end
                    default: state <= RX_PREAMBLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdio_rate_regs.sv
module mdio_rate_regs
    import mdio_rate_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h10,
    parameter logic [ADDR_W-1:0] EXT_ADDR  = 5'h11,
    parameter logic [ADDR_W-1:0] EXT_INIT  = 5'h1F,
    parameter int                RST_BIT   = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata,
    output rate_e             rate,
    output logic              core_reset,
    output logic [ADDR_W-1:0] ext_addr
);
    logic [DATA_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            ext_addr   <= EXT_INIT;
            core_reset <= 1'b0;
        end else begin
            core_reset <= 1'b0;
            if (wr_req.stb) begin
                if (wr_req.addr == CTRL_ADDR) begin
                    if (wr_req.data[RST_BIT]) begin
                        ctrl_q     <= '0;
                        core_reset <= 1'b1;
                    end else begin
                        ctrl_q <= wr_req.data;
                    end
                end else if (wr_req.addr == EXT_ADDR) begin
                    ext_addr <= wr_req.data[ADDR_W-1:0];
                end
            end
        end
    end

    always_comb begin
        if (rd_addr == CTRL_ADDR)     rdata = ctrl_q;
        else if (rd_addr == EXT_ADDR) rdata = {{(DATA_W-ADDR_W){1'b0}}, ext_addr};
        else                          rdata = '0;
    end

    assign rate = rate_from_ctrl(ctrl_q);
endmodule

// File: rtl/mdio_rate_ctrl.sv
module mdio_rate_ctrl
    import mdio_rate_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR    = 5'h02,
    parameter int                PRE_MIN     = 32,
    parameter int                SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mdc,
    input  logic        mdio_mac_out,
    output logic        mdio_mac_in,
    output logic        mdio_oe,
    output logic [1:0]  line_rate,
    output logic        core_reset,
    output logic [4:0]  ext_phy_addr
);
    logic [1:0]        sync_out;
    logic [DATA_W-1:0] rdata;
    frame_hdr_t        hdr;
    logic              frame_match;
    reg_wr_t           wr_req;
    logic              drv_en;
    logic              drv_val;
    rate_e             rate;

    mdio_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .din     ({mdc, mdio_mac_out}),
        .rst_val (2'b01),
        .dout    (sync_out)
    );

    mdio_frame_rx #(.PHY_ADDR(PHY_ADDR), .PRE_MIN(PRE_MIN)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .mdc_s       (sync_out[1]),
        .mdio_s      (sync_out[0]),
        .rdata       (rdata),
        .hdr         (hdr),
        .frame_match (frame_match),
        .wr_req      (wr_req),
        .drv_en      (drv_en),
        .drv_val     (drv_val)
    );

    mdio_rate_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (wr_req),
        .rd_addr    (hdr.regad),
        .rdata      (rdata),
        .rate       (rate),
        .core_reset (core_reset),
        .ext_addr   (ext_phy_addr)
    );

    assign mdio_oe     = drv_en;
    assign mdio_mac_in = drv_en ? drv_val : 1'b1;
    assign line_rate   = rate;
endmodule

// File: rtl/mdio_rate_ctrl_chk.sv
module mdio_rate_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_stb,
    input logic       frame_match,
    input logic       core_reset,
    input logic [1:0] line_rate,
    input logic [4:0] ext_phy_addr,
    input logic       mdio_oe,
    input logic       mdio_mac_in
);
    p_rate_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(line_rate));

    p_one_cycle_reset_r4: assert property (@(posedge clk) disable iff (rst)
        core_reset |=> !core_reset);

    p_reset_clears_rate_r4: assert property (@(posedge clk) disable iff (rst)
        core_reset |-> (line_rate == 2'b00));

    p_drive_needs_match_r5: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> frame_match);

    p_ext_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(ext_phy_addr));

    p_turn_zero_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> !mdio_mac_in);

    p_idle_high_r8: assert property (@(posedge clk) disable iff (rst)
        !mdio_oe |-> mdio_mac_in);
endmodule

bind mdio_rate_ctrl mdio_rate_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_stb       (wr_req.stb),
    .frame_match  (frame_match),
    .core_reset   (core_reset),
    .line_rate    (line_rate),
    .ext_phy_addr (ext_phy_addr),
    .mdio_oe      (mdio_oe),
    .mdio_mac_in  (mdio_mac_in)
);

// File: tb/sim_mdio_rate_ctrl.sv
module sim_mdio_rate_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mdc = 1'b0;
    logic       mdio_mac_out = 1'b1;
    logic       mdio_mac_in;
    logic       mdio_oe;
    logic [1:0] line_rate;
    logic       core_reset;
    logic [4:0] ext_phy_addr;

    localparam logic [4:0] OWN = 5'h02;

    int checks = 0;
    int fails  = 0;
    int rst_pulses = 0;
    bit done = 0;

    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] act_q [$];

    always #5 clk = ~clk;

    mdio_rate_ctrl #(.PHY_ADDR(OWN)) u0 (
        .clk(clk), .rst(rst), .mdc(mdc), .mdio_mac_out(mdio_mac_out),
        .mdio_mac_in(mdio_mac_in), .mdio_oe(mdio_oe), .line_rate(line_rate),
        .core_reset(core_reset), .ext_phy_addr(ext_phy_addr)
    );

    always @(posedge clk) if (core_reset) rst_pulses++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic b, output logic o, output logic oe);
        @(negedge clk) mdio_mac_out = b;
        repeat (3) @(negedge clk);
        o  = mdio_mac_in;
        oe = mdio_oe;
        mdc = 1'b1;
        repeat (4) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        logic o, oe;
        for (int i = n - 1; i >= 0; i--) bit_cycle(v[i], o, oe);
    endtask

    task automatic idle();
        mdio_mac_out = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic frame_wr(input logic [1:0] opc, input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] d, input int npre);
        for (int i = 0; i < npre; i++) send_bits(1, 1);
        send_bits(2'b01, 2);
        send_bits(opc, 2);
        send_bits(phy, 5);
        send_bits(ra, 5);
        send_bits(2'b10, 2);
        send_bits(d, 16);
        idle();
    endtask

    task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        frame_wr(2'b01, phy, ra, d, 32);
    endtask

    // driver side of the scoreboard: pushes expected word, captures returned word
    task automatic rd(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] exp, input string tag);
        logic o, oe;
        logic [15:0] w;
        bit own;
        own = (phy == OWN);
        for (int i = 0; i < 32; i++) send_bits(1, 1);
        send_bits(2'b01, 2);
        send_bits(2'b10, 2);
        send_bits(phy, 5);
        send_bits(ra, 5);
        bit_cycle(1'b1, o, oe);
        chk(oe == 1'b0, "R8", oe, 0);
        bit_cycle(1'b1, o, oe);
        if (own) chk(oe == 1'b1 && o == 1'b0, "R8", {oe, o}, 2'b10);
        else     chk(oe == 1'b0, "R5", oe, 0);
        w = '0;
        for (int i = 15; i >= 0; i--) begin
            bit_cycle(1'b1, o, oe);
            w[i] = o;
            if (!own && oe) chk(1'b0, "R5", oe, 0);
        end
        idle();
        chk(mdio_oe == 1'b0 && mdio_mac_in == 1'b1, "R8", {mdio_oe, mdio_mac_in}, 2'b01);
        if (own) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
            act_q.push_back(w);
        end
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            wait (act_q.size() != 0);
            begin
                logic [15:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(a == e, t, a, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(line_rate == 2'b00, "R1", line_rate, 0);
        chk(core_reset == 1'b0, "R1", core_reset, 0);
        chk(mdio_oe == 1'b0 && mdio_mac_in == 1'b1, "R1", {mdio_oe, mdio_mac_in}, 2'b01);
        chk(ext_phy_addr == 5'h1F, "R1", ext_phy_addr, 5'h1F);

        rd(OWN, 5'h11, 16'h001F, "R6");

        // R2 speed code from bits 6 and 13
        wr(OWN, 5'h10, 16'h2000);
        chk(line_rate == 2'b01, "R2", line_rate, 2'b01);
        rd(OWN, 5'h10, 16'h2000, "R3");
        wr(OWN, 5'h10, 16'h0040);
        chk(line_rate == 2'b10, "R2", line_rate, 2'b10);
        wr(OWN, 5'h10, 16'h2040);
        chk(line_rate == 2'b11, "R2", line_rate, 2'b11);
        wr(OWN, 5'h10, 16'h1234);
        chk(line_rate == 2'b00, "R2", line_rate, 2'b00);
        rd(OWN, 5'h10, 16'h1234, "R3");

        // R4 self-clearing reset bit
        wr(OWN, 5'h10, 16'h2040);
        chk(rst_pulses == 0, "R4", rst_pulses, 0);
        wr(OWN, 5'h10, 16'hA040);
        chk(rst_pulses == 1, "R4", rst_pulses, 1);
        chk(line_rate == 2'b00, "R4", line_rate, 0);
        rd(OWN, 5'h10, 16'h0000, "R4");

        // R6 external PHY address
        wr(OWN, 5'h11, 16'hFFE5);
        chk(ext_phy_addr == 5'h05, "R6", ext_phy_addr, 5'h05);
        rd(OWN, 5'h11, 16'h0005, "R6");

        // R5 foreign PHY address
        wr(OWN, 5'h10, 16'h2000);
        wr(5'h03, 5'h10, 16'h0040);
        chk(line_rate == 2'b01, "R5", line_rate, 2'b01);
        wr(5'h03, 5'h11, 16'h0009);
        chk(ext_phy_addr == 5'h05, "R5", ext_phy_addr, 5'h05);
        rd(5'h03, 5'h10, 16'h0000, "R5");

        // R7 unimplemented addresses
        wr(OWN, 5'h12, 16'hFFFF);
        rd(OWN, 5'h12, 16'h0000, "R7");
        rd(OWN, 5'h05, 16'h0000, "R7");
        rd(OWN, 5'h10, 16'h2000, "R7");
        chk(ext_phy_addr == 5'h05, "R7", ext_phy_addr, 5'h05);

        // R9 short preamble ignored
        frame_wr(2'b01, OWN, 5'h10, 16'h0040, 31);
        chk(line_rate == 2'b01, "R9", line_rate, 2'b01);
        frame_wr(2'b01, OWN, 5'h10, 16'h0040, 32);
        chk(line_rate == 2'b10, "R9", line_rate, 2'b10);

        // R10 invalid opcodes ignored
        frame_wr(2'b11, OWN, 5'h10, 16'h2000, 32);
        chk(line_rate == 2'b10, "R10", line_rate, 2'b10);
        frame_wr(2'b00, OWN, 5'h11, 16'h0001, 32);
        chk(ext_phy_addr == 5'h05, "R10", ext_phy_addr, 5'h05);
        rd(OWN, 5'h10, 16'h0040, "R10");

        chk(rst_pulses == 1, "R4", rst_pulses, 1);
        wait (act_q.size() == 0);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule